// File: doc/BRIEF.md
# Cartridge Bus to Flash Bridge

This block is the glue logic between a 68000-style console cartridge slot and a parallel flash device. It runs on a fast internal clock and treats every bus strobe as an asynchronous, active-low input. Each strobe passes through a synchronizer. A falling edge only counts once it has been seen on two successive samples, so short chip-enable glitches are ignored. A rising edge counts on its first synchronized sample. A read starts only when both the cartridge chip-enable and the column strobe are qualified low. The bridge then lowers the flash chip enable and the flash output enable together and latches the bus address for decoding.

The bus acknowledge line works in one of two modes. In console mode the bridge drives the line low only for accesses whose latched address lies in the window 0x800000 to 0x9FFFFF, and releases it at every other time. In standalone programming mode the line is always driven and copies the flash ready/busy level. A writes to the register area, made with the low write strobe, is captured as an {address, data} word into a small queue that a microcontroller drains.

Top module: `cartflash_bridge`

## Requirements
- R1: After reset, flash_ce_n and flash_oe_n are 1, dtack_oe is 0, fifo_nonempty and fifo_ovf are 0, and the mode is console.
- R2: flash_ce_n and flash_oe_n fall together on the fourth rising clock edge after the first edge at which bus_ce_n and bus_cas_n are both sampled low. Neither strobe low on its own starts a read.
- R3: A strobe that is low at only one sampling edge has no effect on flash_ce_n.
- R4: flash_ce_n and flash_oe_n return to 1, and a console-mode acknowledge is released, by the third rising edge after either bus_ce_n or bus_cas_n is first sampled high.
- R5: In console mode, dtack_oe is 1 and dtack_n is 0 exactly while a read is active whose address, latched at read start, lies in 0x800000..0x9FFFFF inclusive. Otherwise dtack_oe is 0.
- R6: In standalone mode, dtack_oe is 1 at all times and dtack_n equals flash_rdy (1 = ready), delayed by two clock edges.
- R7: mode_sel (0 = console, 1 = standalone) is taken only while no read is active and neither bus_ce_n nor bus_cas_n is qualified low. A change made during a read takes effect only after the bus goes idle.
- R8: One qualified assertion of bus_reg_n with bus_wrl_n also qualified low pushes one entry {bus_addr, bus_data}, however long the strobes stay low. bus_reg_n low with bus_wrl_n high pushes nothing.
- R9: The queue holds FIFO_DEPTH (default 4) entries and returns them in arrival order on fifo_addr/fifo_data. A one-cycle fifo_pop pulse removes the head entry. fifo_nonempty is 1 while any entry is held.
- R10: A push while the queue is full is discarded and sets fifo_ovf, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ce_n | input | 1 | Cartridge chip-enable strobe |
| bus_cas_n | input | 1 | Column strobe that qualifies the address |
| bus_wrl_n | input | 1 | Low-byte write strobe |
| bus_reg_n | input | 1 | Register-area strobe |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_data | input | DATA_W | Bus write data |
| mode_sel | input | 1 | 0 console, 1 standalone programming |
| flash_rdy | input | 1 | Flash ready/busy, 1 = ready |
| flash_ce_n | output | 1 | Flash chip enable |
| flash_oe_n | output | 1 | Flash output enable |
| dtack_oe | output | 1 | Acknowledge pad drive enable (0 = high impedance) |
| dtack_n | output | 1 | Acknowledge pad level when driven |
| fifo_pop | input | 1 | Remove head entry of the capture queue |
| fifo_nonempty | output | 1 | Capture queue holds an entry |
| fifo_addr | output | ADDR_W | Head entry address |
| fifo_data | output | DATA_W | Head entry data |
| fifo_ovf | output | 1 | Sticky capture overflow |

## Verification
The bench walks the acknowledge window across both of its edges and across addresses far outside it. A decoder with an off-by-one or a wrong bit slice would either contend with the console's own acknowledge or stall the processor. It samples the flash enables one cycle before and at the expected fall, so a bridge that acts on a single low sample fails the glitch and timing checks. The same applies to a bridge that starts a read on chip enable alone. It also changes the mode in the middle of a read, where a design that switches at once would flip the acknowledge drive during the access. The capture queue is filled past its depth and then drained. This exposes a queue that overwrites the oldest entry, loses arrival order or clears the overflow flag.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    // Strobe positions inside the synchronizer vector
    localparam int STB_CE    = 0;
    localparam int STB_CAS   = 1;
    localparam int STB_WRL   = 2;
    localparam int STB_REG   = 3;
    localparam int STB_COUNT = 4;

    typedef enum logic {
        MODE_CONSOLE    = 1'b0,
        MODE_STANDALONE = 1'b1
    } bridge_mode_e;

endpackage

// File: rtl/cfb_strobe_sync.sv
module cfb_strobe_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] low_ok
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = raw_n;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    // Low qualifies only after two matching samples; high releases at once
    for (genvar i = 0; i < N; i++) begin : g_qual
        assign low_ok[i] = ~s_q.sync[i] & ~s_q.prev[i];
    end

endmodule

// File: rtl/cfb_access_ctl.sv
module cfb_access_ctl
    import cfb_pkg::*;
#(
    parameter int              ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h800000,
    parameter logic [ADDR_W-1:0] WIN_LAST = 'h9FFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_lo,
    input  logic              cas_lo,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode_req,
    input  logic              rdy_raw,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              dtack_oe,
    output logic              dtack_n,
    output logic              standalone,
    output logic [ADDR_W-1:0] lat_addr
);

    typedef struct packed {
        logic              active;
        logic              ce_n;
        logic              oe_n;
        bridge_mode_e      mode;
        logic              rdy_m;
        logic              rdy_s;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        active: 1'b0, ce_n: 1'b1, oe_n: 1'b1, mode: MODE_CONSOLE,
        rdy_m: 1'b1, rdy_s: 1'b1, addr: '0
    };

    ctl_t c_d, c_q;
    logic qual;
    logic in_win;

    always_comb begin
        qual  = ce_lo & cas_lo;
        c_d   = c_q;
        c_d.active = qual;
        c_d.ce_n   = ~qual;
        c_d.oe_n   = ~qual;
        if (qual && !c_q.active)
            c_d.addr = addr;
        if (!ce_lo && !cas_lo && !c_q.active)
            c_d.mode = mode_req ? MODE_STANDALONE : MODE_CONSOLE;
        c_d.rdy_m = rdy_raw;
        c_d.rdy_s = c_q.rdy_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTL_RST;
        else        c_q <= c_d;
    end

    assign in_win = (c_q.addr >= WIN_BASE) && (c_q.addr <= WIN_LAST);

    always_comb begin
        if (c_q.mode == MODE_STANDALONE) begin
            dtack_oe = 1'b1;
            dtack_n  = c_q.rdy_s;
        end else begin
            dtack_oe = c_q.active & in_win;
            dtack_n  = ~(c_q.active & in_win);
        end
    end

    assign flash_ce_n = c_q.ce_n;
    assign flash_oe_n = c_q.oe_n;
    assign standalone = (c_q.mode == MODE_STANDALONE);
    assign lat_addr   = c_q.addr;

endmodule

// File: rtl/cfb_capture_fifo.sv
module cfb_capture_fifo #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic              nonempty,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr_mem;
        logic [DEPTH-1:0][DATA_W-1:0] data_mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             count;
        logic                         ovf;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  full, do_push, do_pop;

    always_comb begin
        full    = (f_q.count == CNT_FULL);
        do_push = push & ~full;
        do_pop  = pop & (f_q.count != '0);
        f_d     = f_q;
        if (push && full)
            f_d.ovf = 1'b1;
        if (do_push) begin
            f_d.addr_mem[f_q.wr_ptr] = wr_addr;
            f_d.data_mem[f_q.wr_ptr] = wr_data;
            f_d.wr_ptr = (f_q.wr_ptr == PTR_LAST) ? '0 : f_q.wr_ptr + 1'b1;
        end
        if (do_pop)
            f_d.rd_ptr = (f_q.rd_ptr == PTR_LAST) ? '0 : f_q.rd_ptr + 1'b1;
        case ({do_push, do_pop})
            2'b10:   f_d.count = f_q.count + 1'b1;
            2'b01:   f_d.count = f_q.count - 1'b1;
            default: f_d.count = f_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign nonempty = (f_q.count != '0);
    assign rd_addr  = f_q.addr_mem[f_q.rd_ptr];
    assign rd_data  = f_q.data_mem[f_q.rd_ptr];
    assign ovf      = f_q.ovf;

endmodule

// File: rtl/cartflash_bridge.sv
module cartflash_bridge
    import cfb_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter int                DATA_W     = 16,
    parameter int                FIFO_DEPTH = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 'h800000,
    parameter logic [ADDR_W-1:0] WIN_LAST   = 'h9FFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_cas_n,
    input  logic              bus_wrl_n,
    input  logic              bus_reg_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              mode_sel,
    input  logic              flash_rdy,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              dtack_oe,
    output logic              dtack_n,
    input  logic              fifo_pop,
    output logic              fifo_nonempty,
    output logic [ADDR_W-1:0] fifo_addr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_ovf
);

    typedef struct packed {
        logic wr_seen;
    } top_t;

    logic [STB_COUNT-1:0] stb_raw;
    logic [STB_COUNT-1:0] stb_low;
    logic                 wr_lo;
    logic                 push;
    logic                 standalone_w;
    logic [ADDR_W-1:0]    lat_addr_w;
    top_t                 t_d, t_q;

    always_comb begin
        stb_raw          = '1;
        stb_raw[STB_CE]  = bus_ce_n;
        stb_raw[STB_CAS] = bus_cas_n;
        stb_raw[STB_WRL] = bus_wrl_n;
        stb_raw[STB_REG] = bus_reg_n;
    end

    cfb_strobe_sync #(.N(STB_COUNT)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (stb_raw),
        .low_ok (stb_low)
    );

    cfb_access_ctl #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_LAST (WIN_LAST)
    ) ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_lo      (stb_low[STB_CE]),
        .cas_lo     (stb_low[STB_CAS]),
        .addr       (bus_addr),
        .mode_req   (mode_sel),
        .rdy_raw    (flash_rdy),
        .flash_ce_n (flash_ce_n),
        .flash_oe_n (flash_oe_n),
        .dtack_oe   (dtack_oe),
        .dtack_n    (dtack_n),
        .standalone (standalone_w),
        .lat_addr   (lat_addr_w)
    );

    // One push per qualified register-area write
    always_comb begin
        wr_lo       = stb_low[STB_REG] & stb_low[STB_WRL];
        push        = wr_lo & ~t_q.wr_seen;
        t_d.wr_seen = wr_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    cfb_capture_fifo #(
        .DEPTH  (FIFO_DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .wr_addr  (bus_addr),
        .wr_data  (bus_data),
        .pop      (fifo_pop),
        .nonempty (fifo_nonempty),
        .rd_addr  (fifo_addr),
        .rd_data  (fifo_data),
        .ovf      (fifo_ovf)
    );

endmodule

// File: rtl/cfb_bridge_chk.sv
module cfb_bridge_chk #(
    parameter int                ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h800000,
    parameter logic [ADDR_W-1:0] WIN_LAST = 'h9FFFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ce_n,
    input logic              bus_cas_n,
    input logic              flash_ce_n,
    input logic              flash_oe_n,
    input logic              dtack_oe,
    input logic              dtack_n,
    input logic              standalone,
    input logic [ADDR_W-1:0] lat_addr,
    input logic              fifo_ovf
);

    // R2
    read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_ce_n) |-> (!$past(bus_ce_n, 3) && !$past(bus_cas_n, 3) &&
                               !$past(bus_ce_n, 2) && !$past(bus_cas_n, 2)));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_ce_n, 2) || $past(bus_cas_n, 2)) |=> (flash_ce_n && flash_oe_n));

    // R5
    console_dtack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!standalone && dtack_oe) |-> (!dtack_n && !flash_ce_n &&
                                       lat_addr >= WIN_BASE && lat_addr <= WIN_LAST));

    // R6
    standalone_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standalone |-> dtack_oe);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf |=> fifo_ovf);

endmodule

bind cartflash_bridge cfb_bridge_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_LAST (WIN_LAST)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ce_n   (bus_ce_n),
    .bus_cas_n  (bus_cas_n),
    .flash_ce_n (flash_ce_n),
    .flash_oe_n (flash_oe_n),
    .dtack_oe   (dtack_oe),
    .dtack_n    (dtack_n),
    .standalone (standalone_w),
    .lat_addr   (lat_addr_w),
    .fifo_ovf   (fifo_ovf)
);

// File: tb/cartflash_bridge_tb_top.sv
module cartflash_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ce_n = 1'b1, bus_cas_n = 1'b1, bus_wrl_n = 1'b1, bus_reg_n = 1'b1;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        mode_sel = 1'b0, flash_rdy = 1'b1, fifo_pop = 1'b0;
    logic        flash_ce_n, flash_oe_n, dtack_oe, dtack_n;
    logic        fifo_nonempty, fifo_ovf;
    logic [23:0] fifo_addr;
    logic [15:0] fifo_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cartflash_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_ce_n(bus_ce_n), .bus_cas_n(bus_cas_n),
        .bus_wrl_n(bus_wrl_n), .bus_reg_n(bus_reg_n),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .mode_sel(mode_sel), .flash_rdy(flash_rdy),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
        .dtack_oe(dtack_oe), .dtack_n(dtack_n),
        .fifo_pop(fifo_pop), .fifo_nonempty(fifo_nonempty),
        .fifo_addr(fifo_addr), .fifo_data(fifo_data), .fifo_ovf(fifo_ovf)
    );

    // {address, acknowledge expected in console mode}
    localparam logic [24:0] RD_VEC [0:6] = '{
        {24'h7FFFFE, 1'b0},
        {24'h800000, 1'b1},
        {24'h9FFFFE, 1'b1},
        {24'hA00000, 1'b0},
        {24'h000000, 1'b0},
        {24'h8ABCDE, 1'b1},
        {24'hFFFFFE, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_cycle(input logic [23:0] a, input logic win);
        @(negedge clk);
        bus_addr = a; bus_ce_n = 1'b0; bus_cas_n = 1'b0;
        wait_n(3);
        chk(flash_ce_n == 1'b1, "R2", flash_ce_n, 1);
        wait_n(1);
        chk(flash_ce_n == 1'b0 && flash_oe_n == 1'b0, "R2", {flash_ce_n, flash_oe_n}, 0);
        chk(dtack_oe == win, "R5", dtack_oe, win);
        if (win) chk(dtack_n == 1'b0, "R5", dtack_n, 0);
        bus_ce_n = 1'b1; bus_cas_n = 1'b1;
        wait_n(3);
        chk(flash_ce_n && flash_oe_n && !dtack_oe, "R4", {flash_ce_n, flash_oe_n, dtack_oe}, 3'b110);
        wait_n(2);
    endtask

    task automatic reg_write(input logic [23:0] a, input logic [15:0] d, input logic wrl);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_wrl_n = wrl; bus_reg_n = 1'b0;
        wait_n(6);
        bus_reg_n = 1'b1; bus_wrl_n = 1'b1;
        wait_n(4);
    endtask

    task automatic pop_one;
        @(negedge clk); fifo_pop = 1'b1;
        @(negedge clk); fifo_pop = 1'b0;
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk(flash_ce_n && flash_oe_n, "R1", {flash_ce_n, flash_oe_n}, 2'b11);
        chk(!dtack_oe, "R1", dtack_oe, 0);
        chk(!fifo_nonempty && !fifo_ovf, "R1", {fifo_nonempty, fifo_ovf}, 0);

        // R5 window walk
        for (int i = 0; i < 7; i++) read_cycle(RD_VEC[i][24:1], RD_VEC[i][0]);

        // R2 chip enable alone, then column strobe joins
        @(negedge clk); bus_addr = 24'h000100; bus_ce_n = 1'b0;
        wait_n(8);
        chk(flash_ce_n, "R2", flash_ce_n, 1);
        bus_cas_n = 1'b0;
        wait_n(3);
        chk(flash_ce_n, "R2", flash_ce_n, 1);
        wait_n(1);
        chk(!flash_ce_n && !flash_oe_n, "R2", {flash_ce_n, flash_oe_n}, 0);
        // R4 release by column strobe alone
        bus_cas_n = 1'b1;
        wait_n(2);
        chk(!flash_ce_n, "R4", flash_ce_n, 0);
        wait_n(1);
        chk(flash_ce_n && flash_oe_n, "R4", {flash_ce_n, flash_oe_n}, 2'b11);
        bus_ce_n = 1'b1;
        wait_n(4);

        // R3 single-sample chip enable glitch
        @(negedge clk); bus_cas_n = 1'b0;
        wait_n(3);
        bus_ce_n = 1'b0;
        wait_n(1);
        bus_ce_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(flash_ce_n, "R3", flash_ce_n, 1);
        end
        bus_cas_n = 1'b1;
        wait_n(4);

        // R7 mode change during an active read
        flash_rdy = 1'b1;
        @(negedge clk); bus_addr = 24'h800010; bus_ce_n = 1'b0; bus_cas_n = 1'b0;
        wait_n(4);
        chk(dtack_oe && !dtack_n, "R5", {dtack_oe, dtack_n}, 2'b10);
        mode_sel = 1'b1;
        wait_n(3);
        chk(dtack_oe && !dtack_n, "R7", {dtack_oe, dtack_n}, 2'b10);
        bus_ce_n = 1'b1; bus_cas_n = 1'b1;
        wait_n(6);
        chk(dtack_oe && dtack_n, "R7", {dtack_oe, dtack_n}, 2'b11);
        // R6 follows ready/busy
        flash_rdy = 1'b0;
        wait_n(2);
        chk(dtack_oe && !dtack_n, "R6", {dtack_oe, dtack_n}, 2'b10);
        flash_rdy = 1'b1;
        wait_n(2);
        chk(dtack_oe && dtack_n, "R6", {dtack_oe, dtack_n}, 2'b11);
        @(negedge clk); bus_addr = 24'h000200; bus_ce_n = 1'b0; bus_cas_n = 1'b0;
        wait_n(4);
        chk(!flash_ce_n && dtack_oe && dtack_n, "R6", {flash_ce_n, dtack_oe, dtack_n}, 3'b011);
        bus_ce_n = 1'b1; bus_cas_n = 1'b1;
        wait_n(4);
        mode_sel = 1'b0;
        wait_n(3);
        chk(!dtack_oe, "R7", dtack_oe, 0);

        // R8 register area
        reg_write(24'h123456, 16'hBEEF, 1'b1);
        chk(!fifo_nonempty, "R8", fifo_nonempty, 0);
        reg_write(24'hA13000, 16'h1234, 1'b0);
        chk(fifo_nonempty, "R8", fifo_nonempty, 1);
        chk(fifo_addr == 24'hA13000 && fifo_data == 16'h1234, "R8", {fifo_addr, fifo_data}, {24'hA13000, 16'h1234});
        pop_one();
        chk(!fifo_nonempty, "R8", fifo_nonempty, 0);

        // R9 / R10 fill past depth
        for (int k = 0; k < 4; k++) reg_write(24'hA13000 + 24'(2 * k), 16'h5000 + 16'(k), 1'b0);
        chk(fifo_nonempty && !fifo_ovf, "R10", {fifo_nonempty, fifo_ovf}, 2'b10);
        reg_write(24'hA130FE, 16'hDEAD, 1'b0);
        chk(fifo_ovf, "R10", fifo_ovf, 1);
        for (int k = 0; k < 4; k++) begin
            chk(fifo_nonempty, "R9", fifo_nonempty, 1);
            chk(fifo_addr == 24'hA13000 + 24'(2 * k) && fifo_data == 16'h5000 + 16'(k), "R9",
                {fifo_addr, fifo_data}, {24'hA13000 + 24'(2 * k), 16'h5000 + 16'(k)});
            pop_one();
        end
        chk(!fifo_nonempty, "R9", fifo_nonempty, 0);
        chk(fifo_ovf, "R10", fifo_ovf, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule